// File: doc/BRIEF.md
# Edge-Compare Phase Detector with Lock Indicator

This block compares the rising edges of two slow clocks: a divided reference and a divided oscillator feedback. Both are sampled in a fast system clock domain. Whichever edge arrives first sets a hold flop. The flop stays set until the other edge arrives. Once both flops are set, they are cleared together one system clock later. A phase error of a single system clock therefore still yields a one-clock correction pulse, and zero error yields a one-clock coincidence pulse on both sides, so the detector has no dead zone.

The hold flops drive two groups of outputs at once.

- **Double-ended pair.** Two level outputs show which side is leading. A downstream circuit can combine them into a loop error signal.
- **Single-ended output.** This is a source/sink request pair with a drive-enable. When the drive-enable is low, the single-ended output is meant to float (high impedance).

An invert control swaps the roles of the two sides for loops whose oscillator gain has the opposite sign. Each output group has its own enable.

A lock indicator watches each comparison. A comparison ends in the cycle where both flops are set. The indicator rises after a run of consecutive comparisons whose one-sided time stays within a tolerance. It drops on the first comparison that exceeds the tolerance.

Top module: `pfd_lock`

## Requirements
- R1: After reset, `ref_lead`, `vco_lead`, `pump_up`, `pump_dn`, `pump_drive` and `locked` are all 0.
- R2: A rising edge on `ref_in` or `vco_in` is seen at the first clock edge that samples the input high after it was sampled low. The hold flop of that side is set from that clock edge on. Once both hold flops are set, both stay set for exactly one clock and are then cleared. With `invert`=0 and `de_ena`=1, `ref_lead` follows the reference hold flop and `vco_lead` follows the feedback hold flop. If the feedback edge is d>0 clocks later, `ref_lead` is high for d+1 clocks and `vco_lead` for 1 clock; the mirror case holds for d<0.
- R3: Edges seen at the same clock edge raise `ref_lead` and `vco_lead` together for exactly one clock. In that case `pump_up`, `pump_dn` and `pump_drive` stay 0.
- R4: With `invert`=0 and `se_ena`=1, `pump_up` is 1 in each clock where only the reference hold flop is set, and `pump_dn` is 1 where only the feedback hold flop is set. `pump_drive` is 1 exactly when one of them is 1. `pump_up` and `pump_dn` are never 1 together.
- R5: With `invert`=1, the two hold flops trade roles for every output. `ref_lead` and `pump_up` follow the feedback side; `vco_lead` and `pump_dn` follow the reference side.
- R6: `de_ena`=0 forces `ref_lead` and `vco_lead` to 0. `se_ena`=0 forces `pump_up`, `pump_dn` and `pump_drive` to 0. Neither enable changes the other output group.
- R7: A comparison is good when its one-sided time is at most `LOCK_TOL` clocks (default 2). `locked` becomes 1 one clock after the end of the `LOCK_RUN`-th consecutive good comparison (default 4), and not before.
- R8: `locked` returns to 0 one clock after the end of the first comparison that is not good. A bad comparison also restarts the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Divided reference clock, synchronous to clk |
| vco_in | input | 1 | Divided oscillator feedback clock, synchronous to clk |
| invert | input | 1 | 1 swaps the two sides on every output |
| de_ena | input | 1 | Enable for the double-ended pair |
| se_ena | input | 1 | Enable for the single-ended output |
| ref_lead | output | 1 | Double-ended output, reference side |
| vco_lead | output | 1 | Double-ended output, feedback side |
| pump_up | output | 1 | Single-ended source request |
| pump_dn | output | 1 | Single-ended sink request |
| pump_drive | output | 1 | Single-ended drive enable; 0 means high impedance |
| locked | output | 1 | Lock indicator |

## Verification
The end of a comparison clears both hold flops. The lock evaluation of that same comparison happens in the same clock. So the one-sided count must be judged before it is cleared, and the lock run must be updated in the same cycle.

The bench provokes this in two ways:
- with edges of zero, one and tolerance-sized separation, which land the clear and the evaluation on the same edge as the last one-sided clock;
- with good and bad comparisons back to back, so that a bad comparison in the middle of a run must restart the count.

It judges the result from the count of high clocks on each output over a comparison window and from `locked` sampled after each comparison.

// File: rtl/pfd_lock.sv
`timescale 1ns/1ps
module pfd_lock #(
  parameter int LOCK_RUN = 4,
  parameter int LOCK_TOL = 2,
  parameter int CNT_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic vco_in,
  input  logic invert,
  input  logic de_ena,
  input  logic se_ena,
  output logic ref_lead,
  output logic vco_lead,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_drive,
  output logic locked
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);

  logic             ref_q, vco_q;
  logic             hold_r, hold_v;
  logic [CNT_W-1:0] err_cnt;
  logic [RUN_W-1:0] run_cnt;

  wire ref_edge = ref_in & ~ref_q;
  wire vco_edge = vco_in & ~vco_q;
  wire both     = hold_r & hold_v;
  wire single   = hold_r ^ hold_v;
  wire cmp_ok   = err_cnt <= CNT_W'(LOCK_TOL);

  wire up_src = invert ? hold_v : hold_r;
  wire dn_src = invert ? hold_r : hold_v;

  assign ref_lead   = de_ena & up_src;
  assign vco_lead   = de_ena & dn_src;
  assign pump_up    = se_ena & up_src & ~dn_src;
  assign pump_dn    = se_ena & dn_src & ~up_src;
  assign pump_drive = pump_up | pump_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      vco_q  <= 1'b0;
      hold_r <= 1'b0;
      hold_v <= 1'b0;
    end else begin
      ref_q  <= ref_in;
      vco_q  <= vco_in;
      hold_r <= (hold_r & ~both) | ref_edge;
      hold_v <= (hold_v & ~both) | vco_edge;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
      run_cnt <= '0;
      locked  <= 1'b0;
    end else if (both) begin
      err_cnt <= '0;
      if (cmp_ok) begin
        if (run_cnt != RUN_W'(LOCK_RUN)) run_cnt <= run_cnt + 1'b1;
        locked <= run_cnt >= RUN_W'(LOCK_RUN - 1);
      end else begin
        run_cnt <= '0;
        locked  <= 1'b0;
      end
    end else if (single && err_cnt != '1) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfd_lock_chk.sv
`timescale 1ns/1ps
module pfd_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_r,
  input logic hold_v,
  input logic de_ena,
  input logic se_ena,
  input logic ref_lead,
  input logic vco_lead,
  input logic pump_up,
  input logic pump_dn,
  input logic pump_drive,
  input logic locked
);
  AST_PUMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn)); // R4
  AST_COINCIDE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_r && hold_v) |-> !pump_drive); // R3
  AST_SE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !se_ena |-> (!pump_up && !pump_dn && !pump_drive)); // R6
  AST_DE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !de_ena |-> (!ref_lead && !vco_lead)); // R6
  AST_LOCK_AT_CMP_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hold_r && hold_v)); // R7
  AST_UNLOCK_AT_CMP_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(hold_r && hold_v)); // R8
endmodule

bind pfd_lock pfd_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_r(hold_r), .hold_v(hold_v),
  .de_ena(de_ena), .se_ena(se_ena), .ref_lead(ref_lead), .vco_lead(vco_lead),
  .pump_up(pump_up), .pump_dn(pump_dn), .pump_drive(pump_drive), .locked(locked)
);

// File: tb/pfd_lock_bench.sv
`timescale 1ns/1ps
module pfd_lock_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_in = 1'b0, vco_in = 1'b0, invert = 1'b0, de_ena = 1'b1, se_ena = 1'b1;
  logic ref_lead, vco_lead, pump_up, pump_dn, pump_drive, locked;
  int checks = 0, errors = 0;
  int n_r, n_v, n_up, n_dn, n_drv;

  always #2 clk = ~clk;

  pfd_lock u_pfd_lock (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in), .invert(invert),
    .de_ena(de_ena), .se_ena(se_ena), .ref_lead(ref_lead), .vco_lead(vco_lead),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_drive(pump_drive), .locked(locked)
  );

  // columns: d, invert, se_ena, de_ena, exp ref_lead, vco_lead, pump_up, pump_dn, pump_drive
  localparam int NV = 8;
  localparam int VEC [NV][9] = '{
    '{ 3, 0, 1, 1, 4, 1, 3, 0, 3},
    '{-2, 0, 1, 1, 1, 3, 0, 2, 2},
    '{ 0, 0, 1, 1, 1, 1, 0, 0, 0},
    '{ 3, 1, 1, 1, 1, 4, 0, 3, 3},
    '{-2, 1, 1, 1, 3, 1, 2, 0, 2},
    '{ 4, 0, 0, 1, 5, 1, 0, 0, 0},
    '{ 4, 0, 1, 0, 0, 0, 4, 0, 4},
    '{ 1, 0, 1, 1, 2, 1, 1, 0, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    ref_in = 0; vco_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  // one comparison: feedback edge d clocks after the reference edge
  task automatic run_cmp(input int d);
    int ra, va;
    ra = (d < 0) ? 1 - d : 1;
    va = ra + d;
    n_r = 0; n_v = 0; n_up = 0; n_dn = 0; n_drv = 0;
    for (int t = 0; t < 24; t++) begin
      @(negedge clk);
      n_r += int'(ref_lead); n_v += int'(vco_lead);
      n_up += int'(pump_up); n_dn += int'(pump_dn); n_drv += int'(pump_drive);
      ref_in = (t >= ra && t < ra + 8);
      vco_in = (t >= va && t < va + 8);
    end
    ref_in = 0; vco_in = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 ref_lead", int'(ref_lead), 0);
    check("R1 pump_drive", int'(pump_drive), 0);
    check("R1 locked", int'(locked), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      invert = VEC[i][1][0]; se_ena = VEC[i][2][0]; de_ena = VEC[i][3][0];
      run_cmp(VEC[i][0]);
      check($sformatf("R2/R5/R6 v%0d ref_lead", i), n_r, VEC[i][4]);
      check($sformatf("R2/R5/R6 v%0d vco_lead", i), n_v, VEC[i][5]);
      check($sformatf("R4/R5/R6 v%0d pump_up", i), n_up, VEC[i][6]);
      check($sformatf("R4/R5/R6 v%0d pump_dn", i), n_dn, VEC[i][7]);
      check($sformatf("R3/R4 v%0d pump_drive", i), n_drv, VEC[i][8]);
    end
    invert = 0; se_ena = 1; de_ena = 1;

    // R7: three tolerance-edge comparisons are not enough, the fourth locks
    do_reset();
    for (int k = 0; k < 3; k++) run_cmp(2);
    check("R7 not yet locked after 3", int'(locked), 0);
    run_cmp(-2);
    check("R7 locked after 4", int'(locked), 1);
    run_cmp(0);
    check("R7 stays locked", int'(locked), 1);

    // R8: one comparison past tolerance drops lock
    run_cmp(3);
    check("R8 drop on bad comparison", int'(locked), 0);

    // R8: bad comparison inside a run restarts the count
    for (int k = 0; k < 3; k++) run_cmp(1);
    run_cmp(-3);
    for (int k = 0; k < 3; k++) run_cmp(1);
    check("R8 run restarted", int'(locked), 0);
    run_cmp(0);
    check("R7 relock after full run", int'(locked), 1);

    // R1 again: reset clears lock
    do_reset();
    check("R1 locked after reset", int'(locked), 0);
    finish_run();
  end
endmodule